// File: doc/BRIEF.md
# Four-State Strap Pin Mode Decoder

This block reads four configuration straps. Each strap can be tied low, tied high, tied to the measurement clock, or tied to the inverted clock, so one strap carries two bits of setup. The block samples every strap on both clock edges and turns the pair of samples into a 2-bit level code. It then decodes the four codes into operating parameters: precision mode, current-channel gain, bandgap temperature-curve selection, output mode, self-test enable, and hard or soft configuration.

A new set of codes is not taken at once. After power-on reset, the codes must stay unchanged for a long hold. Once a first decode has been accepted, a later change only needs a short hold. While a change is being qualified, the outputs keep the last accepted values and the valid flag is low. A reserved code on the mode strap does not alter the current mode. Instead, it raises an error flag.

Top module: `strap_mode_decoder`

## Requirements
- R1: Each strap is classified from a falling-edge sample followed by the next rising-edge sample, giving code {rise,fall}. Tied low gives 0. Following the clock gives 1 (low at the rising edge, high at the falling edge). Following the inverted clock gives 2. Tied high gives 3.
- R2: Strap 0 code 0 gives low precision at 16x, code 1 gives low precision at 2x, code 2 gives high precision at 2x, and code 3 gives high precision at 16x. `high_prec_o` is 1 for high precision. `gain_log_o` is 0 for 2x and 3 for 16x.
- R3: Strap 1 code 0, 1, 2, 3 picks the curve +50, -140, +130, -40 ppm/°C. `tc_sel_o` gives the rank of the chosen curve in ascending order: 0 for -140, 1 for -40, 2 for +50, 3 for +130.
- R4: `out_mode_o` equals the accepted code of strap 2.
- R5: Strap 3 code 0 gives hard mode with self-test off (`soft_mode_o`=0, `self_test_o`=0). Code 1 gives soft mode with self-test off. Code 3 gives hard mode with self-test on. Self-test is never on in soft mode.
- R6: When strap 3 code 2 (reserved) is accepted, `soft_mode_o` and `self_test_o` keep their previous values and `rsvd_err_o` is 1. The other fields still update. `rsvd_err_o` returns to 0 on the next accepted decode with a non-reserved strap 3.
- R7: During reset, all outputs are 0. The first rising edge after reset release starts the count. If the codes stay unchanged, `cfg_valid_o` and the decoded fields appear after the sixth rising edge (POR_HOLD=5 further periods), and not before.
- R8: After a first acceptance, a code change first seen at rising edge k clears `cfg_valid_o` after edge k. If the codes stay unchanged, the new fields and `cfg_valid_o`=1 appear after edge k+2 (SWITCH_HOLD=2).
- R9: While a change is being qualified, the field outputs hold the last accepted values. A further change during the hold restarts the count from the newest codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Measurement clock; both edges sample the straps |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| strap_i | input | 4 | The four configuration straps |
| cfg_valid_o | output | 1 | Decoded fields are qualified |
| high_prec_o | output | 1 | 1 = high precision, 0 = low power |
| gain_log_o | output | 2 | Current gain, log2(gain)-1 (0=2x, 3=16x) |
| tc_sel_o | output | 2 | Reference temperature-curve rank |
| out_mode_o | output | 2 | Output multiplexer mode code |
| soft_mode_o | output | 1 | 1 = serial (soft) configuration mode |
| self_test_o | output | 1 | Built-in self-test stimulus enabled |
| rsvd_err_o | output | 1 | Accepted mode strap carries the reserved code |

## Verification
A stability counter that is off by one moves the rising edge of `cfg_valid_o` by a cycle. This shows up on the sixth edge after reset or on the second edge after a change. A swapped pairing of the falling and rising samples exchanges codes 1 and 2. Every accepted decode of a clock-tied strap then exposes this in the fields two edges after the change. A lost copy of the previous mode appears as a wrong `soft_mode_o` or `self_test_o` on the decode that accepts the reserved code. A fields register that updates before qualification shows old-versus-new differences one edge after a change.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int NUM_STRAPS = 4;
    localparam int LVL_W      = 2 * NUM_STRAPS;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_CLK  = 2'd1,
        LVL_NCLK = 2'd2,
        LVL_HIGH = 2'd3
    } strap_lvl_e;

    typedef struct packed {
        logic       high_prec;
        logic [1:0] gain_log;
        logic [1:0] tc_sel;
        logic [1:0] out_mode;
        logic       soft_mode;
        logic       self_test;
        logic       rsvd_err;
    } strap_cfg_t;

endpackage

// File: rtl/strap_sampler.sv
// Dual-edge sampling: the falling-edge sample is held in a flop, and the
// rising-edge sample is taken by the consumer's register at the next edge.
module strap_sampler #(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   pin_i,
    output logic [2*N-1:0] lvl_o
);

    logic [N-1:0] fall_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fall_q <= '0;
        end else begin
            fall_q <= pin_i;
        end
    end

    // Level code is {rise, fall}: 0 low, 1 clock, 2 inverted clock, 3 high.
    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign lvl_o[2*g +: 2] = {pin_i[g], fall_q[g]};
    end

endmodule

// File: rtl/strap_qualifier.sv
module strap_qualifier #(
    parameter int W           = 8,
    parameter int POR_HOLD    = 5,
    parameter int SWITCH_HOLD = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl_i,
    output logic [W-1:0] lvl_o,
    output logic         take_o,
    output logic         valid_o
);

    localparam int HOLD_MAX = (POR_HOLD > SWITCH_HOLD) ? POR_HOLD : SWITCH_HOLD;
    localparam int CW       = $clog2(HOLD_MAX + 1);
    localparam int SW       = $clog2(POR_HOLD + 2);

    typedef struct packed {
        logic [W-1:0]  lvl;
        logic [CW-1:0] cnt;
        logic          seen;
        logic          acc;
        logic          valid;
    } qual_t;

    qual_t         s_d, s_q;
    logic [CW-1:0] need;

    always_comb begin
        s_d      = s_q;
        s_d.lvl  = lvl_i;
        s_d.seen = 1'b1;
        need     = s_q.acc ? CW'(SWITCH_HOLD) : CW'(POR_HOLD);
        if (!s_q.seen || (lvl_i != s_q.lvl)) begin
            s_d.cnt   = '0;
            s_d.valid = 1'b0;
        end else if (s_q.cnt < CW'(HOLD_MAX)) begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
        take_o = (s_d.cnt >= need) && (s_d.cnt != '0);
        if (take_o) begin
            s_d.acc   = 1'b1;
            s_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lvl_o   = s_q.lvl;
    assign valid_o = s_q.valid;

    // Edges since reset, saturating; used only by the hold check below.
    logic [SW-1:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (since_q <= SW'(POR_HOLD)) begin
            since_q <= since_q + 1'b1;
        end
    end

    a_r7_por_hold: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (since_q > SW'(POR_HOLD)));

    a_r8_change_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.seen && (lvl_i != lvl_o)) |=> !valid_o);

endmodule

// File: rtl/strap_field_decode.sv
module strap_field_decode
    import strap_pkg::*;
(
    input  logic [LVL_W-1:0] lvl_i,
    input  logic             keep_soft_i,
    input  logic             keep_test_i,
    output strap_cfg_t       cfg_o
);

    logic [1:0] c_prec, c_tc, c_out, c_mode;

    always_comb begin
        c_prec = lvl_i[1:0];
        c_tc   = lvl_i[3:2];
        c_out  = lvl_i[5:4];
        c_mode = lvl_i[7:6];
        cfg_o  = '0;

        cfg_o.high_prec = c_prec[1];
        cfg_o.gain_log  = (c_prec[1] == c_prec[0]) ? 2'd3 : 2'd0;

        case (strap_lvl_e'(c_tc))
            LVL_LOW:  cfg_o.tc_sel = 2'd2;
            LVL_CLK:  cfg_o.tc_sel = 2'd0;
            LVL_NCLK: cfg_o.tc_sel = 2'd3;
            default:  cfg_o.tc_sel = 2'd1;
        endcase

        cfg_o.out_mode = c_out;

        case (strap_lvl_e'(c_mode))
            LVL_LOW: begin
                cfg_o.soft_mode = 1'b0;
                cfg_o.self_test = 1'b0;
            end
            LVL_CLK: begin
                cfg_o.soft_mode = 1'b1;
                cfg_o.self_test = 1'b0;
            end
            LVL_NCLK: begin
                cfg_o.soft_mode = keep_soft_i;
                cfg_o.self_test = keep_test_i;
                cfg_o.rsvd_err  = 1'b1;
            end
            default: begin
                cfg_o.soft_mode = 1'b0;
                cfg_o.self_test = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/strap_mode_decoder.sv
module strap_mode_decoder
    import strap_pkg::*;
#(
    parameter int POR_HOLD    = 5,
    parameter int SWITCH_HOLD = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_STRAPS-1:0] strap_i,
    output logic                  cfg_valid_o,
    output logic                  high_prec_o,
    output logic [1:0]            gain_log_o,
    output logic [1:0]            tc_sel_o,
    output logic [1:0]            out_mode_o,
    output logic                  soft_mode_o,
    output logic                  self_test_o,
    output logic                  rsvd_err_o
);

    logic [LVL_W-1:0] lvl_raw;
    logic [LVL_W-1:0] lvl_q;
    logic             take;
    strap_cfg_t       dec, cfg_d, cfg_q;

    strap_sampler #(.N(NUM_STRAPS)) i_sampler (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (strap_i),
        .lvl_o (lvl_raw)
    );

    strap_qualifier #(
        .W           (LVL_W),
        .POR_HOLD    (POR_HOLD),
        .SWITCH_HOLD (SWITCH_HOLD)
    ) i_qualifier (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_raw),
        .lvl_o   (lvl_q),
        .take_o  (take),
        .valid_o (cfg_valid_o)
    );

    // At an accepting edge the fresh codes equal lvl_q, so the decode
    // works from the registered codes and has no path from the pins.
    strap_field_decode i_decode (
        .lvl_i       (lvl_q),
        .keep_soft_i (cfg_q.soft_mode),
        .keep_test_i (cfg_q.self_test),
        .cfg_o       (dec)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (take) begin
            cfg_d = dec;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign high_prec_o = cfg_q.high_prec;
    assign gain_log_o  = cfg_q.gain_log;
    assign tc_sel_o    = cfg_q.tc_sel;
    assign out_mode_o  = cfg_q.out_mode;
    assign soft_mode_o = cfg_q.soft_mode;
    assign self_test_o = cfg_q.self_test;
    assign rsvd_err_o  = cfg_q.rsvd_err;

    a_r5_selftest_only_hard: assert property (@(posedge clk) disable iff (!rst_n)
        self_test_o |-> !soft_mode_o);

    a_r6_reserved_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (lvl_q[7:6] == 2'd2)) |=>
            ($stable(soft_mode_o) && $stable(self_test_o) && rsvd_err_o));

    a_r9_fields_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(cfg_q));

    a_r2_gain_pairs_precision: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_valid_o |-> ((gain_log_o == 2'd0) || (gain_log_o == 2'd3)));

endmodule

// File: tb/test_strap_mode_decoder.sv
module test_strap_mode_decoder;

    logic       clk = 1'b0;
    logic       ck_d = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sel = 8'h00;
    logic [3:0] pins;

    logic       cfg_valid, high_prec, soft_mode, self_test, rsvd_err;
    logic [1:0] gain_log, tc_sel, out_mode;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int e_hp, e_gain, e_tc, e_om, e_soft, e_st, e_err;

    strap_mode_decoder i_strap_mode_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .strap_i     (pins),
        .cfg_valid_o (cfg_valid),
        .high_prec_o (high_prec),
        .gain_log_o  (gain_log),
        .tc_sel_o    (tc_sel),
        .out_mode_o  (out_mode),
        .soft_mode_o (soft_mode),
        .self_test_o (self_test),
        .rsvd_err_o  (rsvd_err)
    );

    // 50 MHz clock; ck_d is a strap wire following the clock 2 ns late.
    initial begin
        forever begin
            #8 clk = 1'b1;
            #2 ck_d = 1'b1;
            #8 clk = 1'b0;
            #2 ck_d = 1'b0;
        end
    end

    always_comb begin
        for (int i = 0; i < 4; i++) begin
            case (sel[2*i +: 2])
                2'd0:    pins[i] = 1'b0;
                2'd1:    pins[i] = ck_d;
                2'd2:    pins[i] = ~ck_d;
                default: pins[i] = 1'b1;
            endcase
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            finish_run();
        end
    end

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected fields from a code vector; mode bits keep their old value
    // when the mode strap carries the reserved code.
    task automatic expect_from(input int v);
        int c0, c1, c2, c3, rank;
        int ppm [4];
        ppm = '{50, -140, 130, -40};
        c0 = v & 3;
        c1 = (v >> 2) & 3;
        c2 = (v >> 4) & 3;
        c3 = (v >> 6) & 3;
        e_hp   = (c0 >= 2) ? 1 : 0;
        e_gain = (c0 == 0 || c0 == 3) ? 3 : 0;
        rank = 0;
        for (int j = 0; j < 4; j++) begin
            if (ppm[j] < ppm[c1]) rank++;
        end
        e_tc = rank;
        e_om = c2;
        if (c3 == 2) begin
            e_err = 1;
        end else begin
            e_err  = 0;
            e_soft = (c3 == 1) ? 1 : 0;
            e_st   = (c3 == 3) ? 1 : 0;
        end
    endtask

    task automatic check_fields(input string why);
        chk({why, " R1 R2 high_prec"}, int'(high_prec), e_hp);
        chk({why, " R1 R2 gain_log"}, int'(gain_log), e_gain);
        chk({why, " R1 R3 tc_sel"}, int'(tc_sel), e_tc);
        chk({why, " R1 R4 out_mode"}, int'(out_mode), e_om);
        chk({why, " R5 R6 soft_mode"}, int'(soft_mode), e_soft);
        chk({why, " R5 R6 self_test"}, int'(self_test), e_st);
        chk({why, " R6 rsvd_err"}, int'(rsvd_err), e_err);
    endtask

    task automatic clear_exp();
        e_hp = 0; e_gain = 0; e_tc = 0; e_om = 0;
        e_soft = 0; e_st = 0; e_err = 0;
    endtask

    task automatic por_sequence(input logic [7:0] v);
        rst_n = 1'b0;
        sel = v;
        step();
        step();
        clear_exp();
        chk("R7 reset valid", int'(cfg_valid), 0);
        check_fields("R7 reset");
        rst_n = 1'b1;
        for (int k = 1; k <= 5; k++) begin
            step();
            chk("R7 por hold valid", int'(cfg_valid), 0);
            check_fields("R7 por hold");
        end
        step();
        chk("R7 por accept valid", int'(cfg_valid), 1);
        expect_from(int'(v));
        check_fields("R7 por accept");
    endtask

    initial begin
        clear_exp();
        step();

        // Power-on with a mix of static and clock-tied straps.
        por_sequence(8'b11_01_10_00);

        // Sweep every code vector (R8 timing, R1-R6 decoding).
        for (int v = 0; v < 256; v++) begin
            sel = v[7:0];
            step();
            chk("R8 valid drops", int'(cfg_valid), 0);
            check_fields("R9 hold old");
            step();
            chk("R8 still qualifying", int'(cfg_valid), 0);
            check_fields("R9 hold old");
            step();
            chk("R8 accept valid", int'(cfg_valid), 1);
            expect_from(v);
            check_fields("R8 accept");
        end

        // Interrupted change: the short-lived codes are never accepted.
        sel = 8'h00;
        step();
        chk("R9 glitch valid", int'(cfg_valid), 0);
        sel = 8'hFF;
        step();
        chk("R9 restart valid", int'(cfg_valid), 0);
        check_fields("R9 restart hold");
        step();
        chk("R9 restart count", int'(cfg_valid), 0);
        check_fields("R9 restart hold");
        step();
        chk("R9 restart accept", int'(cfg_valid), 1);
        check_fields("R9 restart accept");

        // Reserved mode strap straight out of reset keeps the reset mode.
        e_soft = 0;
        e_st = 0;
        por_sequence(8'b10_00_00_00);
        chk("R6 reserved from reset err", int'(rsvd_err), 1);

        // Soft mode, then reserved: soft mode must be retained.
        sel = 8'b01_10_01_11;
        step(); step(); step();
        expect_from(int'(sel));
        check_fields("R5 soft accept");
        sel = 8'b10_10_01_11;
        step(); step(); step();
        expect_from(int'(sel));
        chk("R6 soft kept", int'(soft_mode), 1);
        check_fields("R6 reserved after soft");

        finish_run();
    end

endmodule